// File: doc/BRIEF.md
# Asynchronous Parallel ROM Read Controller

This block sits between a synchronous host and an external asynchronous read-only memory that has a 21-bit word address and a 16-bit data bus. The host presents one request at a time with a valid/ready handshake. The controller then runs a complete bus cycle on the memory side: it drives the address, pulls the active-low chip enable low, and later pulls the active-low output enable low. It samples the data bus only once every access interval has run out. It returns the word with a one-cycle valid strobe, and after that it releases both enables and waits for the bus to float before it accepts another request.

The upper quarter of the address space, where both of the two highest address bits are set, holds no data. A request there gets an error response, and no bus cycle is run for it. Between accesses the chip enable stays high, so the memory sits in its low-current deselected state. All access intervals are counts of clock cycles, rounded up from the memory's nanosecond figures. They are captured from configuration inputs once, just after reset.

Cycle numbering used below: cycle 0 is the first clock cycle in which the chip enable is low. It begins at the clock edge that accepts the request. With configured counts NA (address access), NC (chip-enable access), NO (output-enable access), NF (bus float) and NRC (minimum read cycle), let T = max(NA, NC), S = max(1, T - NO), D = max(T, S + NO, S + 1) and X = max(D + 1 + NF, NRC, D + 2).

Top module: `rom_read_ctrl`

## Requirements
- R1: A request is accepted only on a clock edge where req_valid and req_ready are both high. req_ready is high only while the controller is idle and its timing configuration has been captured. A request held during a bus cycle waits, and it is accepted in the first cycle the controller becomes idle again.
- R2: A request whose address bits 20 and 19 are both 1 runs no bus cycle. mem_ce_n stays high and mem_addr keeps its previous value. In the cycle after the accepting edge, rsp_valid=1 and rsp_err=1 with rsp_data=0, and req_ready stays high.
- R3: While in reset and while idle, mem_ce_n=1 and mem_oe_n=1, and rsp_valid=0 in reset.
- R4: For an accepted request to the populated region, mem_addr takes the request address and mem_ce_n goes low on the accepting edge. mem_addr then holds steady until the next accepted request.
- R5: mem_oe_n goes low S cycles after mem_ce_n goes low.
- R6: The data bus is captured on the edge that ends cycle D-1. In cycle D, rsp_valid=1, rsp_err=0 and rsp_data holds the word, and both enables are still low during that cycle.
- R7: Both enables rise together at the start of cycle D+1. req_ready returns high in cycle X.
- R8: The five timing counts are captured from the configuration inputs on the first clock edge after reset is released. Later changes on those inputs have no effect until the next reset.
- R9: mem_oe_n is never low while mem_ce_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_t_addr | input | 8 | Address access time in cycles (NA) |
| cfg_t_ce | input | 8 | Chip-enable access time in cycles (NC) |
| cfg_t_oe | input | 8 | Output-enable access time in cycles (NO) |
| cfg_t_float | input | 8 | Bus float time after release in cycles (NF) |
| cfg_t_cycle | input | 8 | Minimum read cycle in cycles (NRC) |
| req_valid | input | 1 | Host request |
| req_addr | input | 21 | Word address of the request |
| req_ready | output | 1 | Controller idle and able to accept |
| mem_addr | output | 21 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_data | input | 16 | Memory data bus |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_err | output | 1 | Response is for the unpopulated region |
| rsp_data | output | 16 | Returned word |

## Verification
The bench's memory model returns a poison word until the address, chip enable and output enable have each been held for their own configured count. A controller that samples one cycle early, or that waits only for the shortest interval instead of the longest, therefore returns wrong data. Three timing sets are used, each making a different interval the last to finish: output-enable dominated, address dominated, and read-cycle dominated. A controller that pins the output-enable start to a fixed point, or that drops one term of the maximum, shows up as a wrong output-enable delay or a wrong response cycle. The addresses on either side of the empty-region boundary are tried. A decoder that tests only one top bit would either start a bus cycle there or reject a valid word. A request held high through a running cycle, and configuration inputs changed after load, catch a controller that accepts early or keeps reloading its timing.

// File: rtl/rom_rd_pkg.sv
`timescale 1ns/1ps
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT_CE,
    ST_OE_ASSERT,
    ST_WAIT_DATA,
    ST_SAMPLE,
    ST_RELEASE,
    ST_TURNAROUND
  } rd_state_e;

endpackage

// File: rtl/rom_rd_region.sv
`timescale 1ns/1ps
// Flags addresses in the unpopulated top quarter (two highest bits set).
module rom_rd_region #(
  parameter int AW = 21
) (
  input  logic [AW-1:0] addr,
  output logic          empty
);

  assign empty = addr[AW-1] & addr[AW-2];

endmodule

// File: rtl/rom_rd_timing.sv
`timescale 1ns/1ps
// Captures the cycle counts once after reset and stores the derived
// schedule points: OE start, sample point, and return-to-idle point.
module rom_rd_timing #(
  parameter int CW          = 8,
  parameter int TW          = CW + 2,
  parameter int DEF_T_ADDR  = 12,
  parameter int DEF_T_CE    = 12,
  parameter int DEF_T_OE    = 6,
  parameter int DEF_T_FLOAT = 6,
  parameter int DEF_T_CYCLE = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_t_addr,
  input  logic [CW-1:0] cfg_t_ce,
  input  logic [CW-1:0] cfg_t_oe,
  input  logic [CW-1:0] cfg_t_float,
  input  logic [CW-1:0] cfg_t_cycle,
  output logic          loaded,
  output logic [TW-1:0] oe_start,
  output logic [TW-1:0] sample_at,
  output logic [TW-1:0] idle_at
);

  localparam int PW = 3 * TW;

  function automatic logic [PW-1:0] derive(
    input logic [CW-1:0] na,
    input logic [CW-1:0] nc,
    input logic [CW-1:0] no,
    input logic [CW-1:0] nf,
    input logic [CW-1:0] nrc
  );
    logic [TW-1:0] t_acc;
    logic [TW-1:0] s;
    logic [TW-1:0] d;
    logic [TW-1:0] x;
    t_acc = (na > nc) ? TW'(na) : TW'(nc);
    s     = (t_acc > TW'(no)) ? (t_acc - TW'(no)) : TW'(1);
    d     = t_acc;
    if ((s + TW'(no)) > d) d = s + TW'(no);
    if ((s + TW'(1)) > d)  d = s + TW'(1);
    x     = d + TW'(1) + TW'(nf);
    if (TW'(nrc) > x)      x = TW'(nrc);
    if ((d + TW'(2)) > x)  x = d + TW'(2);
    return {s, d, x};
  endfunction

  localparam logic [PW-1:0] DEF_PACK = derive(CW'(DEF_T_ADDR), CW'(DEF_T_CE),
                                              CW'(DEF_T_OE), CW'(DEF_T_FLOAT),
                                              CW'(DEF_T_CYCLE));

  logic [PW-1:0] pack_d;
  logic [PW-1:0] pack_q;
  logic          ld_en;

  always_comb begin
    pack_d = derive(cfg_t_addr, cfg_t_ce, cfg_t_oe, cfg_t_float, cfg_t_cycle);
    ld_en  = ~loaded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      pack_q <= DEF_PACK;
    end else if (ld_en) begin
      loaded <= 1'b1;
      pack_q <= pack_d;
    end
  end

  assign oe_start  = pack_q[PW-1:2*TW];
  assign sample_at = pack_q[2*TW-1:TW];
  assign idle_at   = pack_q[TW-1:0];

endmodule

// File: rtl/rom_rd_fsm.sv
`timescale 1ns/1ps
// Bus-cycle sequencer: one cycle counter from chip-enable assertion,
// enables decoded from the state register.
module rom_rd_fsm
  import rom_rd_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_ok,
  input  logic [TW-1:0] oe_start,
  input  logic [TW-1:0] sample_at,
  input  logic [TW-1:0] idle_at,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          addr_empty,
  output logic          req_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data
);

  rd_state_e     st_q;
  rd_state_e     st_d;
  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_d;
  logic [TW-1:0] cnt_inc;
  logic          cnt_en;
  logic          take_bus;
  logic          take_err;
  logic          capture;
  logic          rsp_en;
  logic [AW-1:0] addr_q;
  logic          rsp_valid_q;
  logic          rsp_err_q;
  logic [DW-1:0] rsp_data_q;

  assign req_ready = cfg_ok & (st_q == ST_IDLE);
  assign take_bus  = req_ready & req_valid & ~addr_empty;
  assign take_err  = req_ready & req_valid & addr_empty;
  assign cnt_inc   = cnt_q + TW'(1);
  assign rsp_en    = capture | take_err;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_inc;
    cnt_en  = 1'b1;
    capture = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d  = '0;
        cnt_en = take_bus;
        if (take_bus) st_d = ST_SETUP;
      end
      ST_SETUP, ST_WAIT_CE: begin
        st_d = (cnt_inc >= oe_start) ? ST_OE_ASSERT : ST_WAIT_CE;
      end
      ST_OE_ASSERT, ST_WAIT_DATA: begin
        if (cnt_inc >= sample_at) begin
          st_d    = ST_SAMPLE;
          capture = 1'b1;
        end else begin
          st_d = ST_WAIT_DATA;
        end
      end
      ST_SAMPLE: begin
        st_d = ST_RELEASE;
      end
      ST_RELEASE, ST_TURNAROUND: begin
        st_d = (cnt_inc >= idle_at) ? ST_IDLE : ST_TURNAROUND;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (take_bus) begin
      addr_q <= req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= rsp_en;
      rsp_err_q   <= take_err;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_data_q <= '0;
    end else if (rsp_en) begin
      rsp_data_q <= capture ? mem_data : '0;
    end
  end

  assign mem_addr  = addr_q;
  assign mem_ce_n  = (st_q == ST_IDLE) | (st_q == ST_RELEASE) | (st_q == ST_TURNAROUND);
  assign mem_oe_n  = ~((st_q == ST_OE_ASSERT) | (st_q == ST_WAIT_DATA) | (st_q == ST_SAMPLE));
  assign rsp_valid = rsp_valid_q;
  assign rsp_err   = rsp_err_q;
  assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/rom_read_ctrl.sv
`timescale 1ns/1ps
module rom_read_ctrl #(
  parameter int AW          = 21,
  parameter int DW          = 16,
  parameter int CW          = 8,
  parameter int DEF_T_ADDR  = 12,
  parameter int DEF_T_CE    = 12,
  parameter int DEF_T_OE    = 6,
  parameter int DEF_T_FLOAT = 6,
  parameter int DEF_T_CYCLE = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cfg_t_addr,
  input  logic [CW-1:0] cfg_t_ce,
  input  logic [CW-1:0] cfg_t_oe,
  input  logic [CW-1:0] cfg_t_float,
  input  logic [CW-1:0] cfg_t_cycle,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          req_ready,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  input  logic [DW-1:0] mem_data,
  output logic          rsp_valid,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_data
);

  localparam int TW = CW + 2;

  logic          cfg_ok;
  logic [TW-1:0] oe_start;
  logic [TW-1:0] sample_at;
  logic [TW-1:0] idle_at;
  logic          addr_empty;

  rom_rd_timing #(
    .CW(CW), .TW(TW),
    .DEF_T_ADDR(DEF_T_ADDR), .DEF_T_CE(DEF_T_CE), .DEF_T_OE(DEF_T_OE),
    .DEF_T_FLOAT(DEF_T_FLOAT), .DEF_T_CYCLE(DEF_T_CYCLE)
  ) u_timing (
    .clk(clk), .rst_n(rst_n),
    .cfg_t_addr(cfg_t_addr), .cfg_t_ce(cfg_t_ce), .cfg_t_oe(cfg_t_oe),
    .cfg_t_float(cfg_t_float), .cfg_t_cycle(cfg_t_cycle),
    .loaded(cfg_ok), .oe_start(oe_start), .sample_at(sample_at), .idle_at(idle_at)
  );

  rom_rd_region #(.AW(AW)) u_region (
    .addr(req_addr), .empty(addr_empty)
  );

  rom_rd_fsm #(.AW(AW), .DW(DW), .TW(TW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_ok(cfg_ok),
    .oe_start(oe_start), .sample_at(sample_at), .idle_at(idle_at),
    .req_valid(req_valid), .req_addr(req_addr), .addr_empty(addr_empty),
    .req_ready(req_ready), .mem_addr(mem_addr), .mem_ce_n(mem_ce_n),
    .mem_oe_n(mem_oe_n), .mem_data(mem_data),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

endmodule

// File: rtl/rom_read_ctrl_chk.sv
`timescale 1ns/1ps
module rom_read_ctrl_chk #(
  parameter int AW = 21
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic [AW-1:0] req_addr,
  input logic          req_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          rsp_valid,
  input logic          rsp_err
);

  AST_STANDBY_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n)); // R3

  AST_OE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_ce_n); // R9

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R4

  AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_addr[AW-1] && req_addr[AW-2]))
      |=> (!mem_ce_n && mem_addr == $past(req_addr))); // R4

  AST_NO_EMPTY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> !(mem_addr[AW-1] && mem_addr[AW-2])); // R2

  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_addr[AW-1] && req_addr[AW-2])
      |=> (mem_ce_n && $stable(mem_addr) && rsp_valid && rsp_err && req_ready)); // R2

  AST_DATA_WITH_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (!mem_ce_n && !mem_oe_n)); // R6

  AST_JOINT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |-> $rose(mem_oe_n)); // R7

endmodule

bind rom_read_ctrl rom_read_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/rom_read_ctrl_bench.sv
`timescale 1ns/1ps
module rom_read_ctrl_bench;
  localparam int AW = 21;
  localparam int DW = 16;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] cfg_t_addr, cfg_t_ce, cfg_t_oe, cfg_t_float, cfg_t_cycle;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n;
  logic [DW-1:0] mem_data;
  logic          rsp_valid, rsp_err;
  logic [DW-1:0] rsp_data;

  always #5 clk = ~clk;

  rom_read_ctrl u_rom_read_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_t_addr(cfg_t_addr), .cfg_t_ce(cfg_t_ce), .cfg_t_oe(cfg_t_oe),
    .cfg_t_float(cfg_t_float), .cfg_t_cycle(cfg_t_cycle),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_data(mem_data), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  int na, nc, no, nf, nrc;
  int exp_s, exp_d, exp_x;
  logic [AW-1:0] last_bus;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    return a[15:0] ^ {a[20:16], 11'h2B5};
  endfunction

  // Memory model: poison until every interval has elapsed.
  int ca = 0, cc = 0, co = 0;
  logic [AW-1:0] pa = '0;
  always @(negedge clk) begin
    if (mem_addr !== pa) ca = 1; else if (ca < 100000) ca++;
    if (mem_ce_n) cc = 0; else cc++;
    if (mem_oe_n) co = 0; else co++;
    pa = mem_addr;
  end
  assign mem_data = (!mem_ce_n && !mem_oe_n && ca >= na && cc >= nc && cc > 0 &&
                     co >= no && co > 0) ? rom_word(mem_addr) : 16'hDEAD;

  typedef struct {
    logic [DW-1:0] data;
    logic          err;
    int            due;
  } exp_t;
  exp_t sb[$];

  // Monitor / scoreboard
  int ce_fall = 0;
  logic mce = 1'b1, moe = 1'b1;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (mce && !mem_ce_n) ce_fall = cyc;
      if (moe && !mem_oe_n) begin
        chk(cyc - ce_fall == exp_s, "R5", "OE delay after CE", cyc - ce_fall, exp_s);
        chk(!mem_ce_n, "R9", "CE low while OE low", mem_ce_n, 0);
      end
      if (rsp_valid) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R6", "unexpected response", 1, 0);
        end else begin
          e = sb.pop_front();
          chk(rsp_err == e.err, e.err ? "R2" : "R6", "error flag", rsp_err, e.err);
          chk(rsp_data == e.data, e.err ? "R2" : "R6", "response data", rsp_data, e.data);
          chk(cyc == e.due, e.err ? "R2" : "R6", "response cycle", cyc, e.due);
        end
      end
    end
    mce = mem_ce_n;
    moe = mem_oe_n;
  end

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic start(input int a, input int c, input int o, input int f, input int r);
    int t;
    na = a; nc = c; no = o; nf = f; nrc = r;
    t = imax(na, nc);
    exp_s = imax(1, t - no);
    exp_d = imax(imax(t, exp_s + no), exp_s + 1);
    exp_x = imax(imax(exp_d + 1 + nf, nrc), exp_d + 2);
    cfg_t_addr = CW'(a); cfg_t_ce = CW'(c); cfg_t_oe = CW'(o);
    cfg_t_float = CW'(f); cfg_t_cycle = CW'(r);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_ce_n == 1'b1, "R3", "CE in reset", mem_ce_n, 1);
    chk(mem_oe_n == 1'b1, "R3", "OE in reset", mem_oe_n, 1);
    chk(rsp_valid == 1'b0, "R3", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    chk(req_ready == 1'b0, "R8", "ready before config load", req_ready, 0);
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after config load", req_ready, 1);
    last_bus = mem_addr;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag);
    exp_t e;
    int c0;
    bit emp;
    emp = a[20] & a[19];
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    c0 = cyc + 1;
    e.data = emp ? '0 : rom_word(a);
    e.err  = emp;
    e.due  = emp ? c0 : c0 + exp_d;
    sb.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    if (emp) begin
      chk(mem_ce_n == 1'b1, "R2", "CE stays high for empty region", mem_ce_n, 1);
      chk(mem_addr == last_bus, "R2", "bus address unchanged", mem_addr, last_bus);
      chk(req_ready == 1'b1, "R2", "still ready after error", req_ready, 1);
    end else begin
      chk(mem_addr == a && !mem_ce_n, "R4", "address and CE on accept edge", mem_addr, a);
      last_bus = a;
      while (!req_ready) @(negedge clk);
      chk(cyc == c0 + exp_x, tag, "ready return cycle", cyc, c0 + exp_x);
      chk(mem_ce_n && mem_oe_n, "R3", "standby while idle", {mem_ce_n, mem_oe_n}, 2'b11);
    end
  endtask

  task automatic b2b(input logic [AW-1:0] a1, input logic [AW-1:0] a2);
    exp_t e;
    int c0, c1;
    bit hold_bad;
    hold_bad = 1'b0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a1;
    c0 = cyc + 1;
    e.data = rom_word(a1); e.err = 1'b0; e.due = c0 + exp_d;
    sb.push_back(e);
    @(negedge clk);
    req_addr = a2;
    while (!req_ready) begin
      if (mem_addr !== a1) hold_bad = 1'b1;
      @(negedge clk);
    end
    c1 = cyc + 1;
    e.data = rom_word(a2); e.err = 1'b0; e.due = c1 + exp_d;
    sb.push_back(e);
    chk(c1 - c0 == exp_x + 1, "R1", "held request accepted at first idle", c1 - c0, exp_x + 1);
    chk(!hold_bad, "R4", "address held through cycle", hold_bad, 0);
    @(negedge clk);
    req_valid = 1'b0;
    last_bus = a2;
    while (!req_ready) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R1 watchdog expired: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cfg_t_addr = '0; cfg_t_ce = '0; cfg_t_oe = '0; cfg_t_float = '0; cfg_t_cycle = '0;
    // Address and CE dominate, OE placed late
    start(12, 12, 6, 5, 12);
    cfg_t_addr = 8'd1; cfg_t_ce = 8'd1; cfg_t_oe = 8'd1; cfg_t_float = 8'd1; cfg_t_cycle = 8'd1;
    do_read(21'h012345, "R8");
    do_read(21'h100000, "R7");
    do_read(21'h080000, "R7");
    do_read(21'h17FFFF, "R7");
    do_read(21'h180000, "R2");
    do_read(21'h1FFFFF, "R2");
    b2b(21'h0A5A5A, 21'h155555);
    // OE interval dominates
    start(3, 5, 8, 3, 4);
    do_read(21'h000001, "R7");
    do_read(21'h1C0001, "R2");
    do_read(21'h07FFFE, "R7");
    b2b(21'h123456, 21'h054321);
    // Read cycle time dominates
    start(10, 4, 2, 1, 20);
    do_read(21'h0F0F0F, "R7");
    do_read(21'h1ABCDE, "R2");
    b2b(21'h170000, 21'h000000);
    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R6", "all responses delivered", sb.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule